// File: doc/BRIEF.md
# Prioritized Level Interrupt Controller

This block gathers interrupt requests from a set of peripheral sources. Each source has a fixed priority level from 1 to 7. The block masks the sources one by one and sends a 3-bit level code to a processor core. The code names the highest enabled pending level that is above every level the core is now servicing. When the core acknowledges a level, the block answers one cycle later with an 8-bit vector number. The upper five bits of that number come from a writable base register, and the lower three bits are the level being acknowledged.

Software uses a small register bus with four registers: mask, pending, status and vector base. Masked sources still show in the pending register, so software can poll them. When several sources share a level, the block gives them no order among themselves. The service routine reads the pending register and chooses. Level-type sources clear on their own when the request goes away. Edge-type sources hold their request until software clears it. A level counts as in service from its acknowledge until no unmasked source at that level is pending.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: `irq_lvl` is a register. It shows the highest level (1..7) that has an unmasked pending source, provided that level is strictly above the highest in-service level. Otherwise it shows 0. By default sources 0 and 1 are at level 1, and source k is at level k for k = 2..7.
- R2: After reset every source is masked, so the mask register reads 0xFF. A masked source still sets its pending bit, but it never raises `irq_lvl`.
- R3: A real acknowledge returns `vec_num` = {base[7:3], acknowledged level}.
- R4: The base register resets to 0x40. Its low three bits read as 0. A write below 0x40 stores 0x40, and any other write stores its upper five bits.
- R5: An acknowledge for level 0, or for a level with no unmasked pending source, returns the spurious vector 0x18. It puts nothing in service.
- R6: `vec_valid` is high for exactly the one cycle after each cycle in which `ack_stb` is high.
- R7: A level in service blocks presentation of its own level and of every lower level. A level leaves service once it has no unmasked pending source, and the blocked lower level then appears.
- R8: A level-type source (sources 0..5) reaches its pending bit three clock edges after the input changes: two synchronizer flops, then the pending flop. Writing 1 to its pending bit does nothing.
- R9: An edge-type source (sources 6 and 7) sets its pending bit on a synchronized rising edge. The bit stays set after the input falls. Writing 1 to that bit at address 1 clears it, and a new edge in the same cycle wins over the clear.
- R10: The status register reads as pending AND NOT mask.
- R11: Sources that share a level both show in the pending register. One acknowledge for that level returns that level's single vector.
- R12: A read with `bus_rd` high places the addressed register on `bus_rdata` at the next edge. The addresses are 0 mask, 1 pending, 2 status, 3 base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | N_SRC | Asynchronous request inputs |
| irq_lvl | output | 3 | Level presented to the core, 0 when idle |
| ack_stb | input | 1 | Acknowledge strobe from the core |
| ack_lvl | input | 3 | Level being acknowledged |
| vec_valid | output | 1 | Vector number valid |
| vec_num | output | 8 | Vector number |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
The bench drives a higher level in while a lower one is in service, and drives an equal or lower level in while a level is in service. A design that compares with greater-or-equal, or that ignores the in-service state, would re-present a level the core is already handling. It acknowledges empty levels and level 0, which a careless decode would answer with a base-derived vector instead of 0x18. It writes base values below 0x40, as well as clear writes aimed at both level-type and edge-type sources. A missing clamp, or a clear that reaches a level source, shows up directly in the read-back values. A cycle-level reference model also compares every output on every clock, so an extra or missing synchronizer stage is caught.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int LVL_W = 3;
  localparam int NUM_LVL = 7;
  localparam logic [7:0] SPUR_VEC = 8'h18;
  localparam logic [4:0] BASE_RST = 5'b01000;

  typedef enum logic [1:0] {
    RA_MASK = 2'd0,
    RA_PEND = 2'd1,
    RA_STAT = 2'd2,
    RA_BASE = 2'd3
  } reg_addr_e;

  // highest set bit among levels 1..7, 0 when none
  function automatic logic [LVL_W-1:0] top_level(input logic [NUM_LVL:0] v);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int l = 1; l <= NUM_LVL; l++)
      if (v[l]) r = LVL_W'(l);
    return r;
  endfunction
endpackage

// File: rtl/lic_src.sv
module lic_src #(
  parameter bit EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic req_in,
  input  logic clr,
  output logic pend
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= req_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  generate
    if (EDGE) begin : g_edge
      always_ff @(posedge clk) begin
        if (rst) pend <= 1'b0;
        else if (s2 && !s3) pend <= 1'b1;
        else if (clr) pend <= 1'b0;
      end
      // R9: a set bit survives unless cleared
      p_edge_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (pend && !clr) |=> pend);
    end else begin : g_level
      always_ff @(posedge clk) begin
        if (rst) pend <= 1'b0;
        else pend <= s2;
      end
      // R8: level pending tracks the synchronized input, clears ignored
      p_level_follow_r8: assert property (@(posedge clk) disable iff (rst)
        pend == $past(s2));
    end
  endgenerate
endmodule

// File: rtl/lic_prio.sv
module lic_prio
  import lic_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter logic [N_SRC*LVL_W-1:0] SRC_LVL = '0
) (
  input  logic [N_SRC-1:0]  pend,
  input  logic [N_SRC-1:0]  mask,
  output logic [NUM_LVL:0]  lvl_pend
);
  always_comb begin
    lvl_pend = '0;
    for (int i = 0; i < N_SRC; i++)
      if (pend[i] && !mask[i])
        lvl_pend[SRC_LVL[i*LVL_W +: LVL_W]] = 1'b1;
    lvl_pend[0] = 1'b0;
  end
endmodule

// File: rtl/lic_regs.sv
module lic_regs
  import lic_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter logic [N_SRC-1:0] EDGE_SRC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  input  logic [N_SRC-1:0] pend,
  output logic [7:0]       bus_rdata,
  output logic [N_SRC-1:0] mask,
  output logic [4:0]       vbase,
  output logic [N_SRC-1:0] clr
);
  reg_addr_e ra;
  assign ra = reg_addr_e'(bus_addr);

  assign clr = (bus_wr && ra == RA_PEND) ? (bus_wdata[N_SRC-1:0] & EDGE_SRC) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask  <= '1;
      vbase <= BASE_RST;
    end else if (bus_wr) begin
      if (ra == RA_MASK) mask <= bus_wdata[N_SRC-1:0];
      if (ra == RA_BASE) begin
        if (bus_wdata[7:6] == 2'b00) vbase <= BASE_RST;
        else vbase <= bus_wdata[7:3];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      unique case (ra)
        RA_MASK: bus_rdata <= 8'(mask);
        RA_PEND: bus_rdata <= 8'(pend);
        RA_STAT: bus_rdata <= 8'(pend & ~mask);
        RA_BASE: bus_rdata <= {vbase, 3'b000};
      endcase
    end
  end

  // R4: stored base never falls under 0x40
  p_base_floor_r4: assert property (@(posedge clk) disable iff (rst)
    vbase[4:3] != 2'b00);
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lic_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter logic [N_SRC*LVL_W-1:0] SRC_LVL =
    {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd1},
  parameter logic [N_SRC-1:0] EDGE_SRC = 8'hC0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_src,
  output logic [2:0]       irq_lvl,
  input  logic             ack_stb,
  input  logic [2:0]       ack_lvl,
  output logic             vec_valid,
  output logic [7:0]       vec_num,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata
);
  logic [N_SRC-1:0] pend, mask, clr;
  logic [4:0]       vbase;
  logic [NUM_LVL:0] lvl_pend, insvc, insvc_d;
  logic [2:0]       svc_top, pend_top;
  logic             ack_real;

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
      lic_src #(.EDGE(EDGE_SRC[i])) u_src (
        .clk(clk), .rst(rst), .req_in(irq_src[i]), .clr(clr[i]), .pend(pend[i]));
    end
  endgenerate

  lic_prio #(.N_SRC(N_SRC), .SRC_LVL(SRC_LVL)) u_prio (
    .pend(pend), .mask(mask), .lvl_pend(lvl_pend));

  lic_regs #(.N_SRC(N_SRC), .EDGE_SRC(EDGE_SRC)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pend(pend), .bus_rdata(bus_rdata), .mask(mask),
    .vbase(vbase), .clr(clr));

  assign svc_top  = top_level(insvc);
  assign pend_top = top_level(lvl_pend);
  assign ack_real = ack_stb && (ack_lvl != 3'd0) && lvl_pend[ack_lvl];

  always_comb begin
    insvc_d = insvc & lvl_pend;
    if (ack_real) insvc_d[ack_lvl] = 1'b1;
    insvc_d[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      insvc     <= '0;
      irq_lvl   <= '0;
      vec_valid <= 1'b0;
      vec_num   <= '0;
    end else begin
      insvc     <= insvc_d;
      irq_lvl   <= (pend_top > svc_top) ? pend_top : 3'd0;
      vec_valid <= ack_stb;
      if (ack_stb) vec_num <= ack_real ? {vbase, ack_lvl} : SPUR_VEC;
    end
  end

  // R6: vector valid exactly one cycle after the strobe
  p_vec_next_r6: assert property (@(posedge clk) disable iff (rst)
    ack_stb |=> vec_valid);
  p_vec_only_r6: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(ack_stb));
  // R3: a non-spurious vector carries the acknowledged level
  p_vec_level_r3: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && vec_num != SPUR_VEC) |-> vec_num[2:0] == $past(ack_lvl));
  // R7: a presented level is above everything in service
  p_preempt_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_lvl != 3'd0) |-> irq_lvl > $past(svc_top));
  // R2: a presented level had an unmasked pending source
  p_masked_r2: assert property (@(posedge clk) disable iff (rst)
    (irq_lvl != 3'd0) |-> ((($past(lvl_pend) >> irq_lvl) & 8'd1) != 8'd0));
endmodule

// File: tb/test_lvl_irq_ctrl.sv
module test_lvl_irq_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] irq_src = '0;
  logic [2:0] irq_lvl;
  logic ack_stb = 1'b0;
  logic [2:0] ack_lvl = '0;
  logic vec_valid;
  logic [7:0] vec_num;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lvl_irq_ctrl i_lvl_irq_ctrl (.*);

  // ---------------- behavioural reference model ----------------
  bit [7:0] m_s1, m_s2, m_s3, m_pend, m_mask;
  bit [7:0] m_base, m_rd, m_vn;
  bit [7:0] m_svc;
  int m_irq;
  bit m_vv;

  function automatic int lvl_of(int i); return (i == 0) ? 1 : i; endfunction
  function automatic bit is_edge(int i); return i >= 6; endfunction

  always @(posedge clk) begin
    bit [7:0] lp, np, nsvc;
    int st, pt;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pend = 0; m_mask = 8'hFF;
      m_base = 8'h40; m_rd = 0; m_vn = 0; m_svc = 0; m_irq = 0; m_vv = 0;
    end else begin
      lp = 0;
      for (int i = 0; i < 8; i++) if (m_pend[i] && !m_mask[i]) lp[lvl_of(i)] = 1;
      st = 0; pt = 0;
      for (int l = 1; l < 8; l++) begin
        if (m_svc[l]) st = l;
        if (lp[l]) pt = l;
      end
      for (int i = 0; i < 8; i++) begin
        if (is_edge(i)) begin
          if (m_s2[i] && !m_s3[i]) np[i] = 1;
          else if (bus_wr && bus_addr == 1 && bus_wdata[i]) np[i] = 0;
          else np[i] = m_pend[i];
        end else np[i] = m_s2[i];
      end
      nsvc = m_svc & lp;
      if (ack_stb) begin
        if (ack_lvl != 0 && lp[ack_lvl]) begin
          nsvc[ack_lvl] = 1;
          m_vn = {m_base[7:3], ack_lvl};
        end else m_vn = 8'h18;
      end
      m_vv = ack_stb;
      m_irq = (pt > st) ? pt : 0;
      if (bus_rd)
        case (bus_addr)
          0: m_rd = m_mask;
          1: m_rd = m_pend;
          2: m_rd = m_pend & ~m_mask;
          default: m_rd = m_base;
        endcase
      if (bus_wr && bus_addr == 0) m_mask = bus_wdata;
      if (bus_wr && bus_addr == 3) m_base = (bus_wdata < 8'h40) ? 8'h40 : {bus_wdata[7:3], 3'b000};
      m_svc = nsvc; m_pend = np;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = irq_src;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (!rst && !done) begin
      check("R1 irq_lvl vs model", int'(irq_lvl), m_irq);
      check("R6 vec_valid vs model", int'(vec_valid), int'(m_vv));
      if (vec_valid) check("R3 vec_num vs model", int'(vec_num), int'(m_vn));
      check("R12 rdata vs model", int'(bus_rdata), int'(m_rd));
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic ack(input logic [2:0] l, output logic [7:0] v, output logic ok);
    @(negedge clk); ack_stb = 1; ack_lvl = l;
    @(negedge clk); ack_stb = 0; v = vec_num; ok = vec_valid;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    logic v;
    wait_cyc(3);
    @(negedge clk); rst = 0;
    check("R1 reset irq_lvl", int'(irq_lvl), 0);
    rd(0, d); check("R2 reset mask", d, 8'hFF);
    rd(3, d); check("R4 reset base", d, 8'h40);

    irq_src[2] = 1; wait_cyc(5);
    rd(1, d); check("R2 masked source pending", d, 8'h04);
    check("R2 masked source no irq", int'(irq_lvl), 0);
    rd(2, d); check("R10 status while masked", d, 8'h00);

    wr(0, 8'h00); wait_cyc(3);
    check("R1 level 2 presented", int'(irq_lvl), 2);
    rd(2, d); check("R10 status unmasked", d, 8'h04);
    irq_src[5] = 1; wait_cyc(5);
    check("R1 higher level 5 presented", int'(irq_lvl), 5);

    ack(5, d, v);
    check("R6 vec valid after ack", int'(v), 1);
    check("R3 vector 0x45", d, 8'h45);
    wait_cyc(2);
    check("R7 lower level blocked", int'(irq_lvl), 0);
    irq_src[4] = 1; wait_cyc(5);
    check("R7 level 4 blocked under 5", int'(irq_lvl), 0);
    irq_src[5] = 0; wait_cyc(7);
    check("R7 level 4 after 5 retires", int'(irq_lvl), 4);

    wr(3, 8'h20); rd(3, d); check("R4 low base clamps", d, 8'h40);
    wr(3, 8'hA5); rd(3, d); check("R4 base upper bits", d, 8'hA0);
    ack(4, d, v); check("R3 vector 0xA4", d, 8'hA4);
    ack(3, d, v); check("R5 empty level spurious", d, 8'h18);
    check("R6 valid on spurious", int'(v), 1);
    ack(0, d, v); check("R5 level 0 spurious", d, 8'h18);

    irq_src[7] = 1; wait_cyc(2); irq_src[7] = 0; wait_cyc(6);
    rd(1, d); check("R9 edge bit held", int'(d[7]), 1);
    check("R7 level 7 preempts 4", int'(irq_lvl), 7);
    wr(1, 8'h84); wait_cyc(2);
    rd(1, d); check("R9 edge bit cleared", int'(d[7]), 0);
    check("R8 level bit ignores clear", int'(d[2]), 1);
    wait_cyc(2);
    check("R7 back under service 4", int'(irq_lvl), 0);

    irq_src[4] = 0; irq_src[2] = 0; irq_src[0] = 1; irq_src[1] = 1; wait_cyc(8);
    rd(1, d); check("R11 shared level both pending", d, 8'h03);
    check("R11 shared level presented", int'(irq_lvl), 1);
    ack(1, d, v); check("R11 shared level vector", d, 8'hA1);
    irq_src = '0; wait_cyc(8);
    check("R1 idle after drain", int'(irq_lvl), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait_cyc(20000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule